// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Attention Filter

This block receives asynchronous serial characters that carry nine data bits. A character is one low start bit, nine data bits sent least significant first, and a high stop bit. The line is sampled on a 16x oversampling tick enable. The ninth bit marks the character type: 1 means an address character and 0 means a data character. The serial line comes from an external pin, or from an internal loopback line chosen by a select input.

For a shared bus with several receivers, software can arm an attention state with a one-cycle strobe. While attention is armed, the block throws away every data character without changing any of its outputs. The first address character is delivered as usual, and the attention state then clears itself so that the data characters after it are also delivered. After reading the address, software either leaves attention off to take the message, or arms it again to skip the rest of the message.

A delivered character sets a receive-full flag. A receive interrupt follows that flag while the interrupt enable is high. Sticky framing-error and overrun flags are cleared by a status-read strobe. Baud-rate generation is outside this block.

Top module: `attn_rx`

## Requirements
- R1: After a synchronous reset, `rx_data`, `rx_bit9`, `rx_full`, `rx_irq`, `err_frame`, `err_overrun` and `attn_on` are all 0.
- R2: A character is delivered as follows. After a falling edge, the line must still be low at the 8th tick; this confirms the start bit. Each of the nine data bits is then sampled 16 ticks after the previous sample. The first eight bits go to `rx_data` (first received in bit 0), the ninth bit goes to `rx_bit9`, and `rx_full` goes to 1.
- R3: A low pulse shorter than 8 ticks is not taken as a start bit. No character is delivered and the outputs do not change.
- R4: While `attn_on` is 1, a character whose ninth bit is 0 is dropped. `rx_data`, `rx_bit9`, `rx_full`, `err_frame` and `err_overrun` all keep their values, even when its stop bit is low.
- R5: While `attn_on` is 1, a character whose ninth bit is 1 is delivered and sets `rx_full`, and `attn_on` returns to 0 on the same clock edge.
- R6: A pulse on `attn_set` makes `attn_on` 1 on the next edge. If the pulse falls in the same cycle as the delivery of an address character, the character is still delivered and `attn_on` stays 1.
- R7: A delivered character whose stop bit samples low sets `err_frame`. The flag stays set until `rd_status` is pulsed.
- R8: A character delivered while `rx_full` is 1 sets `err_overrun`, and the new character replaces the buffer contents. A `rd_data` pulse in the same cycle as the delivery prevents the overrun, and `rx_full` stays 1.
- R9: A `rd_data` pulse clears `rx_full`. A `rd_status` pulse clears `err_frame` and `err_overrun`. If a flag is being set in the same cycle as the clear, the set wins.
- R10: `rx_irq` is 1 exactly when `rx_full` is 1 and `rx_ie` was 1 in the cycle before.
- R11: When `two_stop` is 1, the receiver waits one extra bit time after the stop-bit sample before it looks for the next start bit. Characters separated by two stop bits are all received.
- R12: When `lb_sel` is 1, the receiver reads `lb_in` and ignores `rx_pin`. When `lb_sel` is 0, it reads `rx_pin` and ignores `lb_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rx_pin | input | 1 | External serial line (idle high) |
| lb_in | input | 1 | Internal loopback serial line (idle high) |
| lb_sel | input | 1 | 1 selects lb_in as the receive source |
| two_stop | input | 1 | 1 waits for a second stop bit before the next start |
| rx_ie | input | 1 | Receive interrupt enable |
| attn_set | input | 1 | One-cycle strobe that arms the attention state |
| rd_data | input | 1 | One-cycle strobe: buffer has been read, clears rx_full |
| rd_status | input | 1 | One-cycle strobe: status has been read, clears error flags |
| rx_data | output | BYTE_W | Low eight data bits of the last delivered character |
| rx_bit9 | output | 1 | Ninth bit of the last delivered character |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| rx_full | output | 1 | Receive buffer holds an unread character |
| rx_irq | output | 1 | Receive interrupt |
| attn_on | output | 1 | Attention state armed |

## Verification
Two pairs of events can land on the same clock edge. A buffer-read strobe can coincide with the delivery of a new character, and the attention-set strobe can coincide with the automatic clearing of attention by an address character. To provoke these, the bench first measures how many cycles pass from the start of a frame to the rise of `rx_full`, always starting frames at the same tick phase. In later frames it pulses `rd_data` or `attn_set` exactly one cycle before that edge. It then expects `rx_full` high with no overrun, or attention still armed with the address character delivered.

// File: rtl/attn_rx_pkg.sv
package attn_rx_pkg;
  typedef enum logic [2:0] {
    FS_IDLE  = 3'd0,
    FS_START = 3'd1,
    FS_BITS  = 3'd2,
    FS_STOP  = 3'd3,
    FS_HOLD  = 3'd4
  } frame_st_e;
endpackage

// File: rtl/attn_rx_sync.sv
module attn_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_pin,
  input  logic lb_in,
  input  logic lb_sel,
  output logic line_s
);
  logic [STAGES-1:0] pipe_q;
  logic              src;

  assign src = lb_sel ? lb_in : rx_pin;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '1;
    else     pipe_q <= {pipe_q[STAGES-2:0], src};
  end

  assign line_s = pipe_q[STAGES-1];
endmodule

// File: rtl/attn_rx_frame.sv
module attn_rx_frame
  import attn_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              two_stop,
  output logic              chr_done,
  output logic [BYTE_W-1:0] chr_data,
  output logic              chr_b9,
  output logic              chr_stop
);
  localparam int CW  = $clog2(OVS);
  localparam int NB  = BYTE_W + 1;
  localparam int BNW = $clog2(NB + 1);
  localparam logic [CW-1:0]  MID_C  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0]  LAST_C = CW'(OVS - 1);
  localparam logic [BNW-1:0] TOP_B  = BNW'(NB - 1);

  frame_st_e      st_q;
  logic [CW-1:0]  cnt_q;
  logic [BNW-1:0] bit_q;
  logic [NB-1:0]  sh_q;
  logic           last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= FS_IDLE;
      cnt_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      last_q   <= 1'b1;
      chr_done <= 1'b0;
      chr_data <= '0;
      chr_b9   <= 1'b0;
      chr_stop <= 1'b0;
    end else begin
      chr_done <= 1'b0;
      if (tick) begin
        unique case (st_q)
          FS_IDLE: begin
            last_q <= line;
            if (last_q && !line) begin
              st_q  <= FS_START;
              cnt_q <= CW'(1);
            end
          end
          FS_START: begin
            if (cnt_q == MID_C) begin
              cnt_q <= '0;
              bit_q <= '0;
              if (!line) st_q <= FS_BITS;
              else begin
                st_q   <= FS_IDLE;
                last_q <= line;
              end
            end else cnt_q <= cnt_q + CW'(1);
          end
          FS_BITS: begin
            if (cnt_q == LAST_C) begin
              cnt_q <= '0;
              sh_q  <= {line, sh_q[NB-1:1]};
              if (bit_q == TOP_B) st_q <= FS_STOP;
              else bit_q <= bit_q + BNW'(1);
            end else cnt_q <= cnt_q + CW'(1);
          end
          FS_STOP: begin
            if (cnt_q == LAST_C) begin
              cnt_q    <= '0;
              chr_done <= 1'b1;
              chr_data <= sh_q[BYTE_W-1:0];
              chr_b9   <= sh_q[NB-1];
              chr_stop <= line;
              last_q   <= line;
              st_q     <= two_stop ? FS_HOLD : FS_IDLE;
            end else cnt_q <= cnt_q + CW'(1);
          end
          FS_HOLD: begin
            if (cnt_q == LAST_C) begin
              cnt_q  <= '0;
              last_q <= line;
              st_q   <= FS_IDLE;
            end else cnt_q <= cnt_q + CW'(1);
          end
          default: st_q <= FS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/attn_rx_buf.sv
module attn_rx_buf #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chr_done,
  input  logic [BYTE_W-1:0] chr_data,
  input  logic              chr_b9,
  input  logic              chr_stop,
  input  logic              attn_set,
  input  logic              rd_data,
  input  logic              rd_status,
  input  logic              rx_ie,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              attn_on
);
  logic accept;
  logic full_nx;

  // A character is taken unless attention is armed and it is a data character.
  assign accept  = chr_done && !(attn_on && !chr_b9);
  assign full_nx = accept ? 1'b1 : (rd_data ? 1'b0 : rx_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_bit9     <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      rx_full     <= 1'b0;
      rx_irq      <= 1'b0;
      attn_on     <= 1'b0;
    end else begin
      rx_full <= full_nx;
      rx_irq  <= full_nx && rx_ie;
      if (accept) begin
        rx_data <= chr_data;
        rx_bit9 <= chr_b9;
      end
      if (attn_set)             attn_on <= 1'b1;
      else if (accept && chr_b9) attn_on <= 1'b0;
      if (accept && !chr_stop)  err_frame <= 1'b1;
      else if (rd_status)       err_frame <= 1'b0;
      if (accept && rx_full && !rd_data) err_overrun <= 1'b1;
      else if (rd_status)                err_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/attn_rx.sv
module attn_rx #(
  parameter int OVS         = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rx_pin,
  input  logic              lb_in,
  input  logic              lb_sel,
  input  logic              two_stop,
  input  logic              rx_ie,
  input  logic              attn_set,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              attn_on
);
  logic              line_s;
  logic              chr_done;
  logic [BYTE_W-1:0] chr_data;
  logic              chr_b9;
  logic              chr_stop;

  attn_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .lb_in(lb_in),
    .lb_sel(lb_sel), .line_s(line_s)
  );

  attn_rx_frame #(.OVS(OVS), .BYTE_W(BYTE_W)) u_frame (
    .clk(clk), .rst(rst), .tick(tick16), .line(line_s), .two_stop(two_stop),
    .chr_done(chr_done), .chr_data(chr_data), .chr_b9(chr_b9), .chr_stop(chr_stop)
  );

  attn_rx_buf #(.BYTE_W(BYTE_W)) u_buf (
    .clk(clk), .rst(rst), .chr_done(chr_done), .chr_data(chr_data),
    .chr_b9(chr_b9), .chr_stop(chr_stop), .attn_set(attn_set),
    .rd_data(rd_data), .rd_status(rd_status), .rx_ie(rx_ie),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .err_frame(err_frame),
    .err_overrun(err_overrun), .rx_full(rx_full), .rx_irq(rx_irq),
    .attn_on(attn_on)
  );
endmodule

// File: rtl/attn_rx_chk.sv
module attn_rx_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              attn_set,
  input logic              rd_data,
  input logic              rd_status,
  input logic              chr_done,
  input logic              chr_b9,
  input logic              chr_stop,
  input logic [BYTE_W-1:0] rx_data,
  input logic              rx_full,
  input logic              err_frame,
  input logic              err_overrun,
  input logic              rx_irq,
  input logic              attn_on
);
  // R4: a dropped data character leaves every visible field untouched
  assert_drop_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (chr_done && attn_on && !chr_b9 && !attn_set && !rd_data && !rd_status) |=>
      ($stable(rx_full) && $stable(rx_data) && $stable(err_frame) && $stable(err_overrun)));

  assert_addr_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (chr_done && attn_on && chr_b9 && !attn_set) |=> (!attn_on && rx_full));

  assert_set_arms_R6: assert property (@(posedge clk) disable iff (rst)
    attn_set |=> attn_on);

  assert_frame_err_R7: assert property (@(posedge clk) disable iff (rst)
    (chr_done && !(attn_on && !chr_b9) && !chr_stop) |=> err_frame);

  assert_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    (chr_done && !(attn_on && !chr_b9) && rx_full && !rd_data) |=> err_overrun);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !chr_done) |=> !rx_full);

  assert_irq_needs_full_R10: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);
endmodule

bind attn_rx attn_rx_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .attn_set(attn_set), .rd_data(rd_data),
  .rd_status(rd_status), .chr_done(chr_done), .chr_b9(chr_b9),
  .chr_stop(chr_stop), .rx_data(rx_data), .rx_full(rx_full),
  .err_frame(err_frame), .err_overrun(err_overrun), .rx_irq(rx_irq),
  .attn_on(attn_on)
);

// File: tb/attn_rx_tb.sv
module attn_rx_tb;
  localparam int BITC   = 32;          // clocks per bit: tick every 2 clocks, 16 ticks
  localparam int FR_CYC = 13 * BITC;   // start + 9 data + stop + 2 idle bits

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_pin = 1'b1, lb_in = 1'b1, lb_sel = 1'b0, two_stop = 1'b0;
  logic       rx_ie = 1'b1, attn_set = 1'b0, rd_data = 1'b0, rd_status = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, err_frame, err_overrun, rx_full, rx_irq, attn_on;
  logic       tick16;
  int         cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick16 = cyc[0];

  attn_rx u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_pin(rx_pin), .lb_in(lb_in),
    .lb_sel(lb_sel), .two_stop(two_stop), .rx_ie(rx_ie), .attn_set(attn_set),
    .rd_data(rd_data), .rd_status(rd_status), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .err_frame(err_frame), .err_overrun(err_overrun),
    .rx_full(rx_full), .rx_irq(rx_irq), .attn_on(attn_on)
  );

  int n_chk = 0, n_bad = 0, dly = -1;
  bit finished = 0;
  logic [7:0] e_data = 0;
  bit e_b9 = 0, e_fe = 0, e_oe = 0, e_full = 0, e_attn = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "rx_data", rx_data, e_data);
    chk(req, "rx_bit9", rx_bit9, e_b9);
    chk(req, "rx_full", rx_full, e_full);
    chk(req, "err_frame", err_frame, e_fe);
    chk(req, "err_overrun", err_overrun, e_oe);
    chk(req, "attn_on", attn_on, e_attn);
    chk(req, "rx_irq", rx_irq, e_full && rx_ie);
  endtask

  // expected effect of one character on the visible state
  task automatic model(input bit b9, input logic [7:0] d, input bit stp,
                       input bit rd_co, input bit set_co);
    bit acc;
    acc = !(e_attn && !b9);
    if (acc) begin
      if (e_full && !rd_co) e_oe = 1;
      if (!stp) e_fe = 1;
      e_full = 1; e_data = d; e_b9 = b9;
    end else if (rd_co) e_full = 0;
    if (set_co) e_attn = 1;
    else if (acc && b9) e_attn = 0;
  endtask

  task automatic align();
    @(negedge clk);
    while (cyc[0] != 1'b0) @(negedge clk);
  endtask

  task automatic send(input bit lb, input bit b9, input logic [7:0] d, input bit stp,
                      input int rd_at, input int set_at, input bit meas);
    logic [8:0] w, j;
    int bi;
    logic b, jb;
    w = {b9, d};
    j = 9'($urandom);
    align();
    lb_sel = lb;
    for (int i = 0; i < FR_CYC; i++) begin
      if (i > 0) @(negedge clk);
      if (meas && dly < 0 && rx_full) dly = i;
      bi = i / BITC;
      if (bi == 0)       begin b = 0;       jb = 0;       end
      else if (bi <= 9)  begin b = w[bi-1]; jb = j[bi-1]; end
      else if (bi == 10) begin b = stp;     jb = 1;       end
      else               begin b = 1;       jb = 1;       end
      rx_pin    = lb ? jb : b;
      lb_in     = lb ? b : jb;
      rd_data   = (i == rd_at);
      attn_set  = (i == set_at);
    end
    @(negedge clk);
    rd_data = 0; attn_set = 0;
    model(b9, d, stp, rd_at >= 0, set_at >= 0);
  endtask

  task automatic pulse_rd();
    rd_data = 1; @(negedge clk); rd_data = 0; e_full = 0; @(negedge clk);
  endtask
  task automatic pulse_stat();
    rd_status = 1; @(negedge clk); rd_status = 0; e_fe = 0; e_oe = 0; @(negedge clk);
  endtask
  task automatic pulse_attn();
    attn_set = 1; @(negedge clk); attn_set = 0; e_attn = 1; @(negedge clk);
  endtask

  initial begin
    #(10 * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit b9r, stpr, lbr;
    process::self().srandom(32'd1234);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_all("R1");

    // R2: plain data character, also measures the delivery latency
    send(0, 0, 8'hA5, 1, -1, -1, 1);
    chk_all("R2");
    if (dly < 1) dly = 1;
    pulse_rd();
    chk_all("R9");

    // R3: short low glitch of 4 ticks
    align();
    rx_pin = 0; repeat (8) @(negedge clk);
    rx_pin = 1; repeat (FR_CYC) @(negedge clk);
    chk_all("R3");

    // R4: attention armed, data characters dropped (one with a bad stop bit)
    pulse_attn();
    chk_all("R6");
    send(0, 0, 8'h11, 1, -1, -1, 0);
    chk_all("R4");
    send(0, 0, 8'h22, 0, -1, -1, 0);
    chk_all("R4");

    // R5: address character delivered, attention clears itself
    send(0, 1, 8'h3C, 1, -1, -1, 0);
    chk_all("R5");
    rx_ie = 0; @(negedge clk); @(negedge clk);
    chk_all("R10");
    rx_ie = 1; @(negedge clk); @(negedge clk);
    chk_all("R10");

    // R8: overrun with buffer still full, then clear
    send(0, 0, 8'h5A, 1, -1, -1, 0);
    chk_all("R8");
    pulse_stat();
    chk_all("R9");

    // R7: framing error
    send(0, 0, 8'h0F, 0, -1, -1, 0);
    chk_all("R7");
    pulse_stat();

    // R8: read strobe coinciding with delivery while full
    send(0, 0, 8'hC3, 1, dly - 1, -1, 0);
    chk_all("R8");

    // R6: attention set coinciding with delivery of an address character
    pulse_rd();
    send(0, 1, 8'h81, 1, -1, dly - 1, 0);
    chk_all("R6");
    pulse_rd();

    // R11 / R12: two stop bits over the loopback line
    two_stop = 1;
    send(1, 1, 8'h66, 1, -1, -1, 0);
    chk_all("R11");
    send(1, 0, 8'h99, 1, -1, -1, 0);
    chk_all("R12");
    pulse_rd();
    two_stop = 0;
    send(0, 0, 8'h44, 1, -1, -1, 0);
    chk_all("R12");

    // random mix
    for (int k = 0; k < 140; k++) begin
      rx_ie    = 1'($urandom);
      two_stop = 1'($urandom);
      lbr      = 1'($urandom);
      b9r      = ($urandom % 3) == 0;
      stpr     = ($urandom % 10) != 0;
      if (($urandom % 4) == 0) pulse_attn();
      send(lbr, b9r, 8'($urandom), stpr, -1, -1, 0);
      chk_all(e_attn ? "R4" : (b9r ? "R5" : "R2"));
      if (($urandom % 2) == 0) pulse_rd();
      if (($urandom % 3) == 0) pulse_stat();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule